// File: doc/BRIEF.md
# BlaMka Quarter-Round Mixing Unit

This block computes one BlaMka mixing function on four 64-bit words. Four updates alternate with four mixes. Each update adds two words plus twice the full product of their low 32-bit halves. Each mix XORs two words and rotates the result right by a fixed amount. A memory-hard hashing engine uses the unit as its inner mixing primitive. Ordering the sixteen-word state, the diagonal shuffle and the block storage all belong to the logic around it.

The unit streams: it accepts a new set of four words on any cycle that `in_valid` is high, and returns the mixed set with `out_valid` after a fixed latency. It has no ready signal, so it never back-pressures. The parameter `STAGED` chooses the register placement. With `STAGED=1` there is one register after each of the four update/mix pairs, for a latency of 4. With `STAGED=0` the whole chain is combinational behind a single output register, for a latency of 1.

Top module: `blamka_g`

## Requirements
- R1: The first step sets a to a + b + 2·(a[31:0]·b[31:0]). The product is the full 64-bit result of the two low halves, and the doubling shifts it left by one and drops bit 63. All sums are taken modulo 2^64, so an all-zero input maps to an all-zero output.
- R2: The second step sets d to (d XOR a) rotated right by 32, using the a from R1.
- R3: The third step applies the same multiply-add to c with d. It then sets b to (b XOR c) rotated right by 24.
- R4: The fourth step repeats the a update with the current a and b. It then sets d to (d XOR a) rotated right by 16.
- R5: The last step repeats the c update with the current c and d. It then sets b to (b XOR c) rotated right by 63, which is a left rotation by 1. The outputs are the resulting a, b, c and d, in port order.
- R6: `out_valid` rises exactly 4 clock edges after an accepted input when `STAGED=1`, and exactly 1 edge after it when `STAGED=0`.
- R7: Every cycle with `in_valid` high produces exactly one `out_valid` cycle. Back-to-back inputs are accepted on consecutive cycles and leave in the same order. No `out_valid` appears without a matching input.
- R8: While `rst_n` is low, `out_valid` is 0. Inputs still in flight when reset is asserted never appear at the output.
- R9: While `out_valid` is low, the four outputs keep the last result. Data on the inputs while `in_valid` is low has no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input words are valid this cycle |
| in_a | input | 64 | Word a in |
| in_b | input | 64 | Word b in |
| in_c | input | 64 | Word c in |
| in_d | input | 64 | Word d in |
| out_valid | output | 1 | Mixed words valid this cycle |
| out_a | output | 64 | Word a out |
| out_b | output | 64 | Word b out |
| out_c | output | 64 | Word c out |
| out_d | output | 64 | Word d out |

## Verification
The bench builds two instances side by side, one with `STAGED=1` and one with `STAGED=0`, and gives them the same stimulus. The staged build tests the stage clock enables with vectors spread across four registers, bubbles between them, and a reset that flushes data still in flight. The flat build tests the one-cycle path through all eight steps at once. Each output is compared with an independent eight-step model. The stimulus covers zero, all-ones, single-bit, carry-heavy and random vectors.

// File: rtl/blamka_pkg.sv
`timescale 1ns/1ps
package blamka_pkg;

  localparam int unsigned WORD_W   = 64;
  localparam int unsigned NUM_HALF = 4;

  // rotation applied after each of the four update/mix pairs
  localparam int unsigned ROT_P0 = 32;
  localparam int unsigned ROT_P1 = 24;
  localparam int unsigned ROT_P2 = 16;
  localparam int unsigned ROT_P3 = 63;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
  } quad_t;

  function automatic int unsigned rot_of(int unsigned idx);
    case (idx)
      0:       return ROT_P0;
      1:       return ROT_P1;
      2:       return ROT_P2;
      default: return ROT_P3;
    endcase
  endfunction

  function automatic word_t rotr(word_t v, int unsigned k);
    return (v >> k) | (v << (WORD_W - k));
  endfunction

endpackage

// File: rtl/bmk_mac.sv
`timescale 1ns/1ps
// x + y + 2 * (low(x) * low(y)), modulo 2^W
module bmk_mac #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] prod;
  logic [W-1:0] dbl;

  always_comb begin
    prod = {{H{1'b0}}, x[H-1:0]} * {{H{1'b0}}, y[H-1:0]};
    dbl  = {prod[W-2:0], 1'b0};
    sum  = x + y + dbl;
  end
endmodule

// File: rtl/bmk_half.sv
`timescale 1ns/1ps
// One update/mix pair. Even SEL: a += b form, d mixed. Odd SEL: c += d form, b mixed.
module bmk_half
  import blamka_pkg::*;
#(
  parameter int unsigned SEL = 0
) (
  input  quad_t din,
  output quad_t dout
);
  localparam int unsigned ROT = rot_of(SEL);

  word_t acc_n;
  word_t mix_x;

  if ((SEL % 2) == 0) begin : g_adb
    bmk_mac #(.W(WORD_W)) u_mac (
      .x  (din.a),
      .y  (din.b),
      .sum(acc_n)
    );
    assign mix_x = din.d ^ acc_n;
    always_comb begin
      dout   = din;
      dout.a = acc_n;
      dout.d = rotr(mix_x, ROT);
    end
  end else begin : g_cdb
    bmk_mac #(.W(WORD_W)) u_mac (
      .x  (din.c),
      .y  (din.d),
      .sum(acc_n)
    );
    assign mix_x = din.b ^ acc_n;
    always_comb begin
      dout   = din;
      dout.c = acc_n;
      dout.b = rotr(mix_x, ROT);
    end
  end
endmodule

// File: rtl/bmk_stage.sv
`timescale 1ns/1ps
// Valid flag with reset plus a data register loaded only under its enable.
module bmk_stage
  import blamka_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_vld,
  input  quad_t din,
  output logic  out_vld,
  output quad_t dout
);
  logic  vld_q, vld_d;
  quad_t dat_q, dat_d;

  always_comb begin
    vld_d = in_vld;
    dat_d = in_vld ? din : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    dat_q <= dat_d;
  end

  assign out_vld = vld_q;
  assign dout    = dat_q;
endmodule

// File: rtl/blamka_g.sv
`timescale 1ns/1ps
module blamka_g
  import blamka_pkg::*;
#(
  parameter bit STAGED = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_a,
  input  logic [63:0] in_b,
  input  logic [63:0] in_c,
  input  logic [63:0] in_d,
  output logic        out_valid,
  output logic [63:0] out_a,
  output logic [63:0] out_b,
  output logic [63:0] out_c,
  output logic [63:0] out_d
);
  quad_t src;
  quad_t res;
  logic  res_vld;

  assign src = {in_a, in_b, in_c, in_d};

  if (STAGED) begin : g_staged
    quad_t [NUM_HALF:0] stg;
    logic  [NUM_HALF:0] vld;

    assign stg[0] = src;
    assign vld[0] = in_valid;

    for (genvar i = 0; i < NUM_HALF; i++) begin : g_step
      quad_t mixed;
      bmk_half #(.SEL(i)) u_half (
        .din (stg[i]),
        .dout(mixed)
      );
      bmk_stage u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (vld[i]),
        .din    (mixed),
        .out_vld(vld[i+1]),
        .dout   (stg[i+1])
      );
    end

    assign res     = stg[NUM_HALF];
    assign res_vld = vld[NUM_HALF];
  end else begin : g_flat
    quad_t [NUM_HALF:0] chain;

    assign chain[0] = src;

    for (genvar i = 0; i < NUM_HALF; i++) begin : g_step
      bmk_half #(.SEL(i)) u_half (
        .din (chain[i]),
        .dout(chain[i+1])
      );
    end

    bmk_stage u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_vld (in_valid),
      .din    (chain[NUM_HALF]),
      .out_vld(res_vld),
      .dout   (res)
    );
  end

  assign out_valid = res_vld;
  assign {out_a, out_b, out_c, out_d} = res;
endmodule

// File: rtl/blamka_g_chk.sv
`timescale 1ns/1ps
module blamka_g_chk #(
  parameter bit STAGED = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_a,
  input logic [63:0] in_b,
  input logic [63:0] in_c,
  input logic [63:0] in_d,
  input logic        out_valid,
  input logic [63:0] out_a,
  input logic [63:0] out_b,
  input logic [63:0] out_c,
  input logic [63:0] out_d
);
  localparam int unsigned LAT = STAGED ? 4 : 1;

  logic [LAT-1:0] vpipe;
  logic [LAT-1:0] zpipe;
  logic           zero_in;

  assign zero_in = in_valid && (in_a == '0) && (in_b == '0) && (in_c == '0) && (in_d == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpipe <= '0;
      zpipe <= '0;
    end else begin
      vpipe[0] <= in_valid;
      zpipe[0] <= zero_in;
      for (int k = 1; k < int'(LAT); k++) begin
        vpipe[k] <= vpipe[k-1];
        zpipe[k] <= zpipe[k-1];
      end
    end
  end

  assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vpipe[LAT-1] |-> out_valid);

  assert_no_orphan_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> vpipe[LAT-1]);

  assert_zero_maps_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    zpipe[LAT-1] |-> (out_a == '0 && out_b == '0 && out_c == '0 && out_d == '0));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_a) && $stable(out_b) && $stable(out_c) && $stable(out_d)));

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_quiet_in_reset_R8: assert (!out_valid);
    end
  end
endmodule

bind blamka_g blamka_g_chk #(.STAGED(STAGED)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_a     (in_a),
  .in_b     (in_b),
  .in_c     (in_c),
  .in_d     (in_d),
  .out_valid(out_valid),
  .out_a    (out_a),
  .out_b    (out_b),
  .out_c    (out_c),
  .out_d    (out_d)
);

// File: tb/blamka_g_tb_top.sv
`timescale 1ns/1ps
module blamka_g_tb_top;

  localparam int LAT_S = 4;
  localparam int LAT_U = 1;
  localparam int NVEC  = 8;

  typedef struct packed {
    logic [255:0] q;
    int unsigned  cyc;
  } exp_t;

  // stimulus table: {a, b, c, d}
  localparam logic [255:0] VEC [0:NVEC-1] = '{
    256'h0,
    {4{64'hFFFF_FFFF_FFFF_FFFF}},
    {64'h1, 64'h0, 64'h0, 64'h0},
    {64'h0, 64'h0, 64'h0, 64'h8000_0000_0000_0000},
    {64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 64'h0, 64'h0},
    {64'h0, 64'h0, 64'hFFFF_FFFF_0000_0000, 64'h1},
    {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h0F1E_2D3C_4B5A_6978, 64'h8796_A5B4_C3D2_E1F0},
    {64'hDEAD_BEEF_0000_0001, 64'h0000_0001_CAFE_F00D, 64'h5555_5555_AAAA_AAAA, 64'h3333_CCCC_3333_CCCC}
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_a, in_b, in_c, in_d;
  logic        s_vld, u_vld;
  logic [63:0] s_a, s_b, s_c, s_d;
  logic [63:0] u_a, u_b, u_c, u_d;
  logic [255:0] s_all, u_all;

  int unsigned n_chk;
  int unsigned n_err;
  int unsigned cyc;
  exp_t        exp_s [$];
  exp_t        exp_u [$];
  logic [255:0] last_s, last_u;

  assign s_all = {s_a, s_b, s_c, s_d};
  assign u_all = {u_a, u_b, u_c, u_d};

  blamka_g #(.STAGED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
    .out_valid(s_vld), .out_a(s_a), .out_b(s_b), .out_c(s_c), .out_d(s_d)
  );

  blamka_g #(.STAGED(1'b0)) dut_u (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
    .out_valid(u_vld), .out_a(u_a), .out_b(u_b), .out_c(u_c), .out_d(u_d)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // ---- reference model of the eight steps ----
  function automatic logic [63:0] ma(logic [63:0] x, logic [63:0] y);
    logic [63:0] p;
    p = {32'd0, x[31:0]} * {32'd0, y[31:0]};
    return x + y + (p << 1);
  endfunction

  function automatic logic [63:0] rr(logic [63:0] v, int k);
    return (v >> k) | (v << (64 - k));
  endfunction

  function automatic logic [255:0] ref_g(logic [255:0] v);
    logic [63:0] a, b, c, d;
    {a, b, c, d} = v;
    a = ma(a, b); d = rr(d ^ a, 32);
    c = ma(c, d); b = rr(b ^ c, 24);
    a = ma(a, b); d = rr(d ^ a, 16);
    c = ma(c, d); b = rr(b ^ c, 63);
    return {a, b, c, d};
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmp_words(input string tag, input logic [255:0] got, input logic [255:0] want);
    check(got[255:192] == want[255:192], {tag, " out_a R1/R4"}, {192'd0, got[255:192]}, {192'd0, want[255:192]});
    check(got[191:128] == want[191:128], {tag, " out_b R3/R5"}, {192'd0, got[191:128]}, {192'd0, want[191:128]});
    check(got[127:64]  == want[127:64],  {tag, " out_c R3/R5"}, {192'd0, got[127:64]},  {192'd0, want[127:64]});
    check(got[63:0]    == want[63:0],    {tag, " out_d R2/R4"}, {192'd0, got[63:0]},    {192'd0, want[63:0]});
  endtask

  // ---- monitors ----
  always @(negedge clk) begin
    if (s_vld) begin
      if (exp_s.size() == 0) begin
        check(1'b0, "staged R7 output without input", s_all, 256'd0);
      end else begin
        exp_t e;
        e = exp_s.pop_front();
        cmp_words("staged", s_all, e.q);
        check((cyc - e.cyc) == LAT_S, "staged R6 latency", 256'(cyc - e.cyc), 256'(LAT_S));
        last_s = s_all;
      end
    end
    if (u_vld) begin
      if (exp_u.size() == 0) begin
        check(1'b0, "flat R7 output without input", u_all, 256'd0);
      end else begin
        exp_t e;
        e = exp_u.pop_front();
        cmp_words("flat", u_all, e.q);
        check((cyc - e.cyc) == LAT_U, "flat R6 latency", 256'(cyc - e.cyc), 256'(LAT_U));
        last_u = u_all;
      end
    end
  end

  task automatic send(input logic [255:0] v);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    {in_a, in_b, in_c, in_d} = v;
    e.q   = ref_g(v);
    e.cyc = cyc;
    exp_s.push_back(e);
    exp_u.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      {in_a, in_b, in_c, in_d} = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0; cyc = 0;
    rst_n = 1'b0; in_valid = 1'b0;
    in_a = '0; in_b = '0; in_c = '0; in_d = '0;
    last_s = '0; last_u = '0;

    // R8: reset state
    repeat (3) @(negedge clk);
    check(s_vld == 1'b0, "staged R8 valid in reset", {255'd0, s_vld}, 256'd0);
    check(u_vld == 1'b0, "flat R8 valid in reset", {255'd0, u_vld}, 256'd0);
    rst_n = 1'b1;
    idle(2);

    // table, back to back (R1..R5 values, R7 streaming)
    for (int i = 0; i < NVEC; i++) send(VEC[i]);
    idle(8);

    // R9: outputs hold while idle inputs toggle
    check(s_all == last_s, "staged R9 hold", s_all, last_s);
    check(u_all == last_u, "flat R9 hold", u_all, last_u);

    // random vectors with bubbles
    for (int i = 0; i < 200; i++) begin
      send({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
    end
    idle(8);
    check(s_all == last_s, "staged R9 hold after random", s_all, last_s);
    check(u_all == last_u, "flat R9 hold after random", u_all, last_u);

    // R8: reset while vectors are in flight
    send(VEC[6]);
    send(VEC[7]);
    send(VEC[1]);
    @(negedge clk);
    in_valid = 1'b0;
    #1 rst_n = 1'b0;
    exp_s.delete();
    exp_u.delete();
    @(negedge clk);
    check(s_vld == 1'b0, "staged R8 flush", {255'd0, s_vld}, 256'd0);
    check(u_vld == 1'b0, "flat R8 flush", {255'd0, u_vld}, 256'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(8);

    // all-ones after reset, then drain
    send({4{64'hFFFF_FFFF_FFFF_FFFF}});
    idle(8);

    // R7: nothing left pending
    check(exp_s.size() == 0, "staged R7 pending", 256'(exp_s.size()), 256'd0);
    check(exp_u.size() == 0, "flat R7 pending", 256'(exp_u.size()), 256'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule